// File: doc/BRIEF.md
# Configuration Image Loader with Per-Block CRC Check

This block takes a configuration image as a stream of 16-bit words and copies its payload into a coefficient memory through a simple write port. Each word is offered with a valid strobe. An image has a fixed frame. It opens with one identifier word. Twelve payload blocks follow, and each block holds 42 data words and ends with its own check word. The loader checks the identifier and every check word. Neither of these is ever written to memory. Any mismatch stops the load and raises a sticky error.

A host load starts with a one-cycle request pulse. The block also has a boot mode, selected by a strap input that is sampled while reset is asserted. In that mode the loader feeds itself a built-in default image through the same checking path, one word per cycle, as soon as reset is released.

Top module: `cfg_stream_loader`

## Requirements
- R1: While reset is asserted with `boot_rom_i` low, and in the first cycle after it, `busy_o`, `done_o`, `error_o` and `mem_we_o` are all low.
- R2: The first word of a load must equal 0x7725. Any other value sets `error_o` at the clock edge that accepts it, clears `busy_o`, and causes no memory write.
- R3: After the identifier come 12 blocks, each made of 42 data words and then one check word. The data words are written in arrival order to addresses 0 through 503, one address after the other. `mem_we_o` rises in the cycle after the word is accepted.
- R4: The identifier word and the check words never produce a write, so a load without errors makes exactly 504 writes.
- R5: The check word of a block is CRC-16 with polynomial 0x1021 and start value 0xFFFF. It is computed MSB first over that block's 42 data words, and the register restarts for every block.
- R6: A check word that does not match sets `error_o` and stops the load. `error_o` stays high, and later words cause no writes, until the next load request.
- R7: `done_o` rises at the clock edge that accepts the last check word, and only when that word matches. It stays high until the next load request. It is never high together with `error_o`.
- R8: A cycle in which `cfg_valid_i` is low does not advance a host load and causes no write.
- R9: When `boot_rom_i` is high during reset, the block loads its default image after reset is released, taking one word per cycle. That image writes data word ((a*0x9E37) mod 65536) XOR 0x5A5A at address a, and it ends with `done_o` high.
- R10: A load request pulse that arrives while `busy_o` is high is ignored, and the current load runs to its end. Words offered while the block is idle cause no writes.
- R11: A load request in the idle state clears `done_o` and `error_o` and restarts framing from the identifier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_rom_i | input | 1 | Boot strap; sampled during reset, it selects a self-load of the default image |
| load_req_i | input | 1 | Pulse that starts a host load when the block is idle |
| cfg_valid_i | input | 1 | Marks `cfg_word_i` as valid in this cycle |
| cfg_word_i | input | 16 | Image word from the host |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 9 | Memory write address |
| mem_data_o | output | 16 | Memory write data |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | The last load finished with all checks passed |
| error_o | output | 1 | The last load stopped on an identifier or check-word mismatch |

## Verification
Suppose the word or block counter slips by one position. The next check word then lands on a data word. The mismatch shows on `error_o` at the end of that block, at most 43 accepted words later, and the count of captured writes comes out different from 504. If the CRC register is not restarted for each block, the error shows at the second check word. A bad address step shows at the very next write as an address that is not consecutive. For the boot path, a wrong word in the default image shows in the captured memory contents once `done_o` rises.

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader #(
  parameter logic [15:0] ID_WORD     = 16'h7725,
  parameter int          NUM_BLOCKS  = 12,
  parameter int          BLOCK_WORDS = 42,
  parameter logic [15:0] CRC_POLY    = 16'h1021,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF,
  parameter int          DEPTH       = NUM_BLOCKS * BLOCK_WORDS,
  parameter int          AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_rom_i,
  input  logic          load_req_i,
  input  logic          cfg_valid_i,
  input  logic [15:0]   cfg_word_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o
);
  localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int IW = $clog2(BLOCK_WORDS + 1);

  logic          busy, from_rom, want_id, done, err;
  logic [BW-1:0] blk;
  logic [IW-1:0] idx;
  logic [AW:0]   addr;
  logic [15:0]   crc;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [15:0] rom_data(input logic [AW:0] a);
    logic [31:0] p;
    p = 32'(a) * 32'h0000_9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  wire         take     = busy && (from_rom || cfg_valid_i);
  wire         in_data  = !want_id && (idx < IW'(BLOCK_WORDS));
  wire         last_blk = (blk == BW'(NUM_BLOCKS - 1));
  wire  [15:0] word     = !from_rom ? cfg_word_i :
                          want_id   ? ID_WORD :
                          in_data   ? rom_data(addr) : crc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= boot_rom_i;
      from_rom   <= boot_rom_i;
      want_id    <= 1'b1;
      blk        <= '0;
      idx        <= '0;
      addr       <= '0;
      crc        <= CRC_INIT;
      done       <= 1'b0;
      err        <= 1'b0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= 1'b0;
      if (!busy && load_req_i) begin
        busy     <= 1'b1;
        from_rom <= 1'b0;
        want_id  <= 1'b1;
        blk      <= '0;
        idx      <= '0;
        addr     <= '0;
        crc      <= CRC_INIT;
        done     <= 1'b0;
        err      <= 1'b0;
      end else if (take) begin
        if (want_id) begin
          if (word != ID_WORD) begin
            err  <= 1'b1;
            busy <= 1'b0;
          end else begin
            want_id <= 1'b0;
          end
        end else if (in_data) begin
          mem_we_o   <= 1'b1;
          mem_addr_o <= addr[AW-1:0];
          mem_data_o <= word;
          addr       <= addr + 1'b1;
          idx        <= idx + 1'b1;
          crc        <= crc_step(crc, word);
        end else if (word != crc) begin
          err  <= 1'b1;
          busy <= 1'b0;
        end else begin
          idx <= '0;
          crc <= CRC_INIT;
          if (last_blk) begin
            done <= 1'b1;
            busy <= 1'b0;
          end else begin
            blk <= blk + 1'b1;
          end
        end
      end
    end
  end

  assign busy_o  = busy;
  assign done_o  = done;
  assign error_o = err;

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done_o && error_o)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done_o && !load_req_i |=> done_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) error_o && !load_req_i |=> error_o); // R6
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n) error_o |-> !busy_o); // R6
  AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mem_we_o |-> $past(busy_o)); // R3
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) mem_we_o |-> (int'(mem_addr_o) < DEPTH)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o && $past(mem_we_o) |-> mem_addr_o == AW'($past(mem_addr_o) + 1'b1)); // R3
  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !from_rom && !cfg_valid_i && !load_req_i |=> !mem_we_o); // R8
endmodule

// File: tb/cfg_stream_loader_bench.sv
`timescale 1ns/1ps
module cfg_stream_loader_bench;
  localparam int NB = 12, BWD = 42, DEPTH = NB * BWD;

  logic        clk = 1'b0, rst_n = 1'b0, boot_rom_i = 1'b0, load_req_i = 1'b0, cfg_valid_i = 1'b0;
  logic [15:0] cfg_word_i = '0;
  logic        mem_we_o, busy_o, done_o, error_o;
  logic [8:0]  mem_addr_o;
  logic [15:0] mem_data_o;

  int errors = 0, checks = 0, wr_cnt = 0, order_err = 0, cycles = 0;
  logic [15:0] cap [DEPTH];
  logic [15:0] expd [DEPTH];

  always #2.5 clk = ~clk;

  cfg_stream_loader u_cfg_stream_loader (
    .clk(clk), .rst_n(rst_n), .boot_rom_i(boot_rom_i), .load_req_i(load_req_i),
    .cfg_valid_i(cfg_valid_i), .cfg_word_i(cfg_word_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .busy_o(busy_o),
    .done_o(done_o), .error_o(error_o));

  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      if (int'(mem_addr_o) != wr_cnt) order_err++;
      if (wr_cnt < DEPTH) cap[wr_cnt] = mem_data_o;
      wr_cnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc16(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 16; i++) begin
      logic fb = r[15] ^ d[15 - i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic clear_cap();
    wr_cnt = 0; order_err = 0;
  endtask

  task automatic start_load();
    @(negedge clk); load_req_i = 1'b1;
    clear_cap();
    @(negedge clk); load_req_i = 1'b0;
  endtask

  int wcount;
  task automatic send(input logic [15:0] w, input int gaps, input int req_at);
    @(negedge clk);
    cfg_valid_i = 1'b1; cfg_word_i = w;
    load_req_i = (wcount == req_at);
    wcount++;
    @(negedge clk);
    cfg_valid_i = 1'b0; load_req_i = 1'b0; cfg_word_i = 16'hDEAD;
    for (int g = 0; g < (wcount % (gaps + 1)); g++) @(negedge clk);
  endtask

  task automatic run_host(input int seed, input logic [15:0] id, input int bad_blk,
                          input int gaps, input int req_at);
    wcount = 0;
    send(id, gaps, req_at);
    for (int b = 0; b < NB; b++) begin
      logic [15:0] c = 16'hFFFF;
      for (int j = 0; j < BWD; j++) begin
        logic [15:0] d = 16'(((b * BWD + j) * 961 + seed * 7919) ^ (seed << 4));
        expd[b * BWD + j] = d;
        c = crc16(c, d);
        send(d, gaps, req_at);
      end
      send((b == bad_blk) ? (c ^ 16'h0100) : c, gaps, req_at);
    end
    @(negedge clk);
  endtask

  function automatic int mem_mismatch(input int n);
    int bad = 0;
    for (int a = 0; a < n; a++) if (cap[a] !== expd[a]) bad++;
    return bad;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !error_o && !mem_we_o, "R1 reset", {busy_o, done_o, error_o, mem_we_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !error_o && !mem_we_o, "R1 after release", {busy_o, done_o, error_o, mem_we_o}, 0);

    clear_cap();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); cfg_valid_i = 1'b1; cfg_word_i = 16'h7725;
    end
    @(negedge clk); cfg_valid_i = 1'b0;
    chk(wr_cnt == 0 && !busy_o, "R10 idle words ignored", wr_cnt, 0);

    start_load();
    run_host(1, 16'h7725, -1, 2, -1);
    chk(done_o && !error_o && !busy_o, "R7 done after good load", {done_o, error_o}, 2);
    chk(wr_cnt == DEPTH, "R4 write count", wr_cnt, DEPTH);
    chk(order_err == 0, "R3 consecutive addresses", order_err, 0);
    chk(mem_mismatch(DEPTH) == 0, "R5 R8 data with gaps", mem_mismatch(DEPTH), 0);
    repeat (20) @(negedge clk);
    chk(done_o, "R7 done sticky", done_o, 1);

    start_load();
    chk(!done_o && busy_o, "R11 request clears done", {done_o, busy_o}, 1);
    run_host(2, 16'h7724, -1, 0, -1);
    chk(error_o && !done_o && !busy_o, "R2 bad id error", {error_o, done_o, busy_o}, 4);
    chk(wr_cnt == 0, "R2 no writes after bad id", wr_cnt, 0);

    start_load();
    chk(!error_o, "R11 request clears error", error_o, 0);
    run_host(3, 16'h7725, 5, 1, -1);
    chk(error_o && !done_o, "R6 bad crc block 5", {error_o, done_o}, 2);
    chk(wr_cnt == 6 * BWD, "R6 writes stop at error", wr_cnt, 6 * BWD);
    chk(mem_mismatch(wr_cnt) == 0 && order_err == 0, "R3 data before error", mem_mismatch(wr_cnt), 0);

    start_load();
    run_host(4, 16'h7725, NB - 1, 0, -1);
    chk(error_o && !done_o, "R7 bad final crc keeps done low", {error_o, done_o}, 2);
    chk(wr_cnt == DEPTH, "R4 all data written before final check", wr_cnt, DEPTH);

    start_load();
    run_host(5, 16'h7725, -1, 1, 100);
    chk(done_o && !error_o, "R10 mid-load request ignored", {done_o, error_o}, 2);
    chk(wr_cnt == DEPTH && order_err == 0 && mem_mismatch(DEPTH) == 0, "R10 load intact", wr_cnt, DEPTH);

    @(negedge clk); rst_n = 1'b0; boot_rom_i = 1'b1;
    repeat (2) @(negedge clk);
    clear_cap();
    rst_n = 1'b1;
    @(negedge clk); boot_rom_i = 1'b0;
    for (int a = 0; a < DEPTH; a++) expd[a] = 16'(a * 32'h9E37) ^ 16'h5A5A;
    for (int k = 0; k < 1000 && !done_o && !error_o; k++) @(negedge clk);
    chk(done_o && !error_o, "R9 boot load done", {done_o, error_o}, 2);
    chk(wr_cnt == DEPTH && order_err == 0, "R9 boot write count", wr_cnt, DEPTH);
    chk(mem_mismatch(DEPTH) == 0, "R9 default image contents", mem_mismatch(DEPTH), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule